// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This unit sits beside the bus interface of an agent on a 32-bit multiplexed address/data bus with a 4-bit command/byte-enable field. It handles parity in both directions. When the agent drives the lanes, it forms the parity bit that the agent puts on the bus one clock later. When the agent receives a phase, it compares the parity bit that arrives one clock later against its own reduction of the received lanes.

A detected mismatch is routed according to the kind of phase:

- An errored data phase raises a one-clock active-low data-parity strobe.
- An errored address phase, or an errored data phase of a special-cycle command, raises a one-clock pull-down request on the shared system-error line.

The block never drives the system-error line high. Two enable inputs gate the strobes. Two sticky flags record each error class until software clears them with write-one-to-clear pulses.

Top module: `bus_parity_unit`

## Requirements
- R1: `par_o` in the clock after any clock equals the XOR of the 32 address/data bits and the 4 command/byte-enable bits of that clock. As a result, those 36 bits plus the parity bit hold an even number of ones.
- R2: `par_oe_o` is high in the clock after a clock in which `drive_i` is high, and low otherwise.
- R3: A received data phase completes at clock t when `rx_data_i` is high, `addr_phase_i` is low, and `irdy_n_i` and `trdy_n_i` are both low. If `special_i` is low at t and `par_i` at t+1 differs from the even parity of the lanes at t, then `perr_n_o` is low in clock t+2 for exactly that clock. This holds provided `perr_en_i` is high at t+1.
- R4: A data phase with `irdy_n_i` or `trdy_n_i` high is not checked. A bad `par_i` after such a phase raises no strobe and sets no flag.
- R5: An address phase (`addr_phase_i` high at t) whose parity mismatches at t+1 drives `serr_pull_o` high in clock t+2, provided `serr_en_i` is high at t+1. `addr_phase_i` takes precedence over `rx_data_i` in the same clock.
- R6: A completed data phase with `special_i` high whose parity mismatches is reported on `serr_pull_o`, not on `perr_n_o`.
- R7: `serr_pull_o` is the only system-error output and is a pull-down request (1 = pull the line low). It is high for exactly one clock per detected error, so back-to-back errors give one pulse per clock.
- R8: With `perr_en_i` low at t+1, a data error raises no `perr_n_o` pulse. With `serr_en_i` low, a system-class error raises no `serr_pull_o` pulse. The sticky flags are set in both cases.
- R9: `perr_flag_o` and `serr_flag_o` go high in clock t+2 for their error class and hold until cleared. A high `clr_perr_i` or `clr_serr_i` at clock c clears the flag in clock c+1. A detection that lands in the same clock as a clear wins, and the flag stays set.
- R10: During and right after reset, `par_oe_o` and `serr_pull_o` are low, `perr_n_o` is high, and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ad_i | input | 32 | Address/data lanes |
| cbe_i | input | 4 | Command/byte-enable lanes |
| par_i | input | 1 | Parity bit seen on the bus (covers the previous clock) |
| drive_i | input | 1 | Agent drives the lanes this clock |
| addr_phase_i | input | 1 | Received address phase this clock |
| rx_data_i | input | 1 | Agent receives a data phase this clock |
| irdy_n_i | input | 1 | Initiator ready, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| special_i | input | 1 | Current transaction is a special cycle |
| perr_en_i | input | 1 | Enable data-parity strobe |
| serr_en_i | input | 1 | Enable system-error pull-down |
| clr_perr_i | input | 1 | Write-one-to-clear for the data-parity flag |
| clr_serr_i | input | 1 | Write-one-to-clear for the system-error flag |
| par_o | output | 1 | Generated parity for the previous clock's lanes |
| par_oe_o | output | 1 | Parity output enable |
| perr_n_o | output | 1 | Data-parity-error strobe, active low |
| serr_pull_o | output | 1 | System-error pull-down request |
| perr_flag_o | output | 1 | Sticky data-parity-error flag |
| serr_flag_o | output | 1 | Sticky system-error flag |

## Verification
Two collisions are provoked on purpose. The first is a new error detection arriving in the same clock as a write-one-to-clear of its flag. Here the flag must remain set, and must clear only once a clear arrives in a quiet clock. The second is a checked phase whose parity clock is itself a new phase, as in back-to-back errored data or address phases. Here one strobe per clock must appear with no merging or loss. The bench builds both with directed sequences and then with random streams. A behavioural model judges every clock's outputs by keeping a pending-phase record and the even parity of the previous clock.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

    typedef enum logic [1:0] {
        PK_NONE = 2'd0,
        PK_DATA = 2'd1,
        PK_ADDR = 2'd2,
        PK_SPEC = 2'd3
    } phase_kind_e;

    typedef struct packed {
        logic par;
        logic oe;
    } gen_state_s;

    typedef struct packed {
        phase_kind_e kind;
        logic        exp_par;
    } chk_state_s;

    typedef struct packed {
        logic perr_n;
        logic serr_pull;
        logic perr_flag;
        logic serr_flag;
    } rep_state_s;

endpackage

// File: rtl/bpu_xor_tree.sv
module bpu_xor_tree #(
    parameter int N = 36
) (
    input  logic [N-1:0] bits_i,
    output logic         par_o
);
    localparam int LVL   = (N > 1) ? $clog2(N) : 1;
    localparam int LEAVES = 1 << LVL;
    localparam int NODES  = 2 * LEAVES - 1;

    logic node [NODES];

    generate
        for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
            if (i < N) begin : g_real
                assign node[LEAVES-1+i] = bits_i[i];
            end else begin : g_pad
                assign node[LEAVES-1+i] = 1'b0;
            end
        end
        for (genvar j = 0; j < LEAVES - 1; j++) begin : g_inner
            assign node[j] = node[2*j+1] ^ node[2*j+2];
        end
    endgenerate

    assign par_o = node[0];
endmodule

// File: rtl/bpu_gen.sv
module bpu_gen
    import bpu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lane_par_i,
    input  logic drive_i,
    output logic par_o,
    output logic par_oe_o
);
    gen_state_s st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.par = lane_par_i;
        st_d.oe  = drive_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign par_o    = st_q.par;
    assign par_oe_o = st_q.oe;

    p_oe_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_i |=> !par_oe_o);
endmodule

// File: rtl/bpu_chk.sv
module bpu_chk
    import bpu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lane_par_i,
    input  logic par_i,
    input  logic addr_phase_i,
    input  logic rx_data_i,
    input  logic irdy_n_i,
    input  logic trdy_n_i,
    input  logic special_i,
    output logic data_err_o,
    output logic sys_err_o
);
    chk_state_s st_d, st_q;
    logic       done_phase;
    logic       mismatch;

    assign done_phase = rx_data_i && !irdy_n_i && !trdy_n_i;

    always_comb begin
        st_d         = st_q;
        st_d.exp_par = lane_par_i;
        if (addr_phase_i)    st_d.kind = PK_ADDR;
        else if (done_phase) st_d.kind = special_i ? PK_SPEC : PK_DATA;
        else                 st_d.kind = PK_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{kind: PK_NONE, exp_par: 1'b0};
        else        st_q <= st_d;
    end

    assign mismatch   = (st_q.kind != PK_NONE) && (par_i != st_q.exp_par);
    assign data_err_o = mismatch && (st_q.kind == PK_DATA);
    assign sys_err_o  = mismatch && (st_q.kind == PK_ADDR || st_q.kind == PK_SPEC);

    p_class_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_err_o && sys_err_o));
    p_unready_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_phase_i && (irdy_n_i || trdy_n_i)) |=> !data_err_o && !sys_err_o);
    p_special_route_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_phase_i && done_phase && special_i) |=> !data_err_o);
endmodule

// File: rtl/bpu_report.sv
module bpu_report
    import bpu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic data_err_i,
    input  logic sys_err_i,
    input  logic perr_en_i,
    input  logic serr_en_i,
    input  logic clr_perr_i,
    input  logic clr_serr_i,
    output logic perr_n_o,
    output logic serr_pull_o,
    output logic perr_flag_o,
    output logic serr_flag_o
);
    rep_state_s st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.perr_n    = !(data_err_i && perr_en_i);
        st_d.serr_pull = sys_err_i && serr_en_i;
        if (data_err_i)      st_d.perr_flag = 1'b1;
        else if (clr_perr_i) st_d.perr_flag = 1'b0;
        if (sys_err_i)       st_d.serr_flag = 1'b1;
        else if (clr_serr_i) st_d.serr_flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{perr_n: 1'b1, serr_pull: 1'b0, perr_flag: 1'b0, serr_flag: 1'b0};
        else        st_q <= st_d;
    end

    assign perr_n_o    = st_q.perr_n;
    assign serr_pull_o = st_q.serr_pull;
    assign perr_flag_o = st_q.perr_flag;
    assign serr_flag_o = st_q.serr_flag;

    p_perr_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(perr_n_o) |-> $past(data_err_i));
    p_serr_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        serr_pull_o |-> $past(sys_err_i));
    p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!perr_en_i && !serr_en_i) |=> perr_n_o && !serr_pull_o);
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        data_err_i |=> perr_flag_o);
    p_flag_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(serr_flag_o) |-> $past(clr_serr_i));
    p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (serr_pull_o && !sys_err_i) |=> !serr_pull_o);
endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit #(
    parameter int AD_W  = 32,
    parameter int CBE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AD_W-1:0]  ad_i,
    input  logic [CBE_W-1:0] cbe_i,
    input  logic             par_i,
    input  logic             drive_i,
    input  logic             addr_phase_i,
    input  logic             rx_data_i,
    input  logic             irdy_n_i,
    input  logic             trdy_n_i,
    input  logic             special_i,
    input  logic             perr_en_i,
    input  logic             serr_en_i,
    input  logic             clr_perr_i,
    input  logic             clr_serr_i,
    output logic             par_o,
    output logic             par_oe_o,
    output logic             perr_n_o,
    output logic             serr_pull_o,
    output logic             perr_flag_o,
    output logic             serr_flag_o
);
    localparam int LANES = AD_W + CBE_W;

    logic lane_par;
    logic data_err;
    logic sys_err;

    bpu_xor_tree #(.N(LANES)) u_tree (
        .bits_i ({ad_i, cbe_i}),
        .par_o  (lane_par)
    );

    bpu_gen u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .lane_par_i (lane_par),
        .drive_i    (drive_i),
        .par_o      (par_o),
        .par_oe_o   (par_oe_o)
    );

    bpu_chk u_chk (
        .clk          (clk),
        .rst_n        (rst_n),
        .lane_par_i   (lane_par),
        .par_i        (par_i),
        .addr_phase_i (addr_phase_i),
        .rx_data_i    (rx_data_i),
        .irdy_n_i     (irdy_n_i),
        .trdy_n_i     (trdy_n_i),
        .special_i    (special_i),
        .data_err_o   (data_err),
        .sys_err_o    (sys_err)
    );

    bpu_report u_rep (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_err_i  (data_err),
        .sys_err_i   (sys_err),
        .perr_en_i   (perr_en_i),
        .serr_en_i   (serr_en_i),
        .clr_perr_i  (clr_perr_i),
        .clr_serr_i  (clr_serr_i),
        .perr_n_o    (perr_n_o),
        .serr_pull_o (serr_pull_o),
        .perr_flag_o (perr_flag_o),
        .serr_flag_o (serr_flag_o)
    );

    p_even_total_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((^$past({ad_i, cbe_i})) ^ par_o) == 1'b0);
    p_oe_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        drive_i |=> par_oe_o);
    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |=> !par_oe_o && perr_n_o && !serr_pull_o && !perr_flag_o && !serr_flag_o);
endmodule

// File: tb/bus_parity_unit_bench.sv
`timescale 1ns/1ps
module bus_parity_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ad_i = '0;
    logic [3:0]  cbe_i = '0;
    logic        par_i = 1'b0, drive_i = 1'b0, addr_phase_i = 1'b0, rx_data_i = 1'b0;
    logic        irdy_n_i = 1'b1, trdy_n_i = 1'b1, special_i = 1'b0;
    logic        perr_en_i = 1'b1, serr_en_i = 1'b1, clr_perr_i = 1'b0, clr_serr_i = 1'b0;
    logic        par_o, par_oe_o, perr_n_o, serr_pull_o, perr_flag_o, serr_flag_o;

    always #4 clk = ~clk;

    bus_parity_unit u_bus_parity_unit (
        .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_i(cbe_i), .par_i(par_i),
        .drive_i(drive_i), .addr_phase_i(addr_phase_i), .rx_data_i(rx_data_i),
        .irdy_n_i(irdy_n_i), .trdy_n_i(trdy_n_i), .special_i(special_i),
        .perr_en_i(perr_en_i), .serr_en_i(serr_en_i), .clr_perr_i(clr_perr_i),
        .clr_serr_i(clr_serr_i), .par_o(par_o), .par_oe_o(par_oe_o),
        .perr_n_o(perr_n_o), .serr_pull_o(serr_pull_o),
        .perr_flag_o(perr_flag_o), .serr_flag_o(serr_flag_o)
    );

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    finished = 0;
    string tag = "R10";
    logic  good_prev = 1'b0;
    logic  g_clr_p = 0, g_clr_s = 0, g_pen = 1, g_sen = 1;

    // behavioural reference state
    logic m_par = 0, m_oe = 0, m_perr_n = 1, m_serr = 0, m_pf = 0, m_sf = 0;
    int   pend_kind = 0;   // 0 none, 1 data, 2 address, 3 special data
    logic pend_par = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_par = 0; m_oe = 0; m_perr_n = 1; m_serr = 0; m_pf = 0; m_sf = 0;
            pend_kind = 0; pend_par = 0;
        end else begin
            bit err, de, se;
            err = (pend_kind != 0) && (pend_par != par_i);
            de  = err && pend_kind == 1;
            se  = err && (pend_kind == 2 || pend_kind == 3);
            m_perr_n = !(de && perr_en_i);
            m_serr   = se && serr_en_i;
            if (de) m_pf = 1; else if (clr_perr_i) m_pf = 0;
            if (se) m_sf = 1; else if (clr_serr_i) m_sf = 0;
            m_par = ^{ad_i, cbe_i};
            m_oe  = drive_i;
            if (addr_phase_i) pend_kind = 2;
            else if (rx_data_i && !irdy_n_i && !trdy_n_i) pend_kind = special_i ? 3 : 1;
            else pend_kind = 0;
            pend_par = ^{ad_i, cbe_i};
        end
    end

    task automatic cmp(input string t, input string nm, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", t, nm, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (!finished) begin
        cmp("R1", "par_o", par_o, m_par);
        cmp("R2", "par_oe_o", par_oe_o, m_oe);
        cmp(tag, "perr_n_o", perr_n_o, m_perr_n);
        cmp(tag, "serr_pull_o", serr_pull_o, m_serr);
        cmp("R9", "perr_flag_o", perr_flag_o, m_pf);
        cmp("R9", "serr_flag_o", serr_flag_o, m_sf);
    end

    // one bus clock; flip corrupts the parity that covers the previous clock
    task automatic step(input logic [31:0] a, input logic [3:0] c, input logic flip,
                        input logic drv, input logic adr, input logic rx,
                        input logic irn, input logic trn, input logic sp);
        @(negedge clk);
        #1;
        ad_i = a; cbe_i = c; par_i = good_prev ^ flip;
        drive_i = drv; addr_phase_i = adr; rx_data_i = rx;
        irdy_n_i = irn; trdy_n_i = trn; special_i = sp;
        perr_en_i = g_pen; serr_en_i = g_sen; clr_perr_i = g_clr_p; clr_serr_i = g_clr_s;
        good_prev = ^{a, c};
    endtask

    task automatic idle(input logic flip);
        step($urandom, 4'($urandom), flip, 0, 0, 0, 1, 1, 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog actual=running expected=done");
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        tag = "R10";
        repeat (3) @(negedge clk);
        #1; rst_n = 1;
        idle(0); idle(0);
        // R1 R2: driven phases with varied lanes, including all-ones and zero
        tag = "R1";
        step(32'hFFFF_FFFF, 4'hF, 0, 1, 0, 0, 0, 0, 0);
        step(32'h0, 4'h0, 0, 1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 6; i++) step($urandom, 4'($urandom), 0, 1, 0, 0, 0, 0, 0);
        idle(0); idle(0);
        // R5: address phase good then bad
        tag = "R5";
        step($urandom, 4'h6, 0, 0, 1, 0, 1, 1, 0); idle(0); idle(0);
        step($urandom, 4'h7, 0, 0, 1, 0, 1, 1, 0); idle(1); idle(0); idle(0);
        // R3: completed data phase, bad parity
        tag = "R3";
        step($urandom, 4'h0, 0, 0, 0, 1, 0, 0, 0); idle(1); idle(0); idle(0);
        // R4: unready phases with bad parity
        tag = "R4";
        step($urandom, 4'h0, 0, 0, 0, 1, 1, 0, 0); idle(1);
        step($urandom, 4'h0, 0, 0, 0, 1, 0, 1, 0); idle(1); idle(0); idle(0);
        // R6: special-cycle data error
        tag = "R6";
        step($urandom, 4'h3, 0, 0, 0, 1, 0, 0, 1); idle(1); idle(0); idle(0);
        // R7: back-to-back errored phases
        tag = "R7";
        step($urandom, 4'h2, 0, 0, 1, 0, 1, 1, 0);
        step($urandom, 4'h2, 1, 0, 1, 0, 1, 1, 0);
        step($urandom, 4'h2, 1, 0, 0, 1, 0, 0, 0);
        step($urandom, 4'h2, 1, 0, 0, 1, 0, 0, 0);
        idle(1); idle(0); idle(0);
        // R8: reporting disabled, flags still set
        tag = "R8";
        g_clr_p = 1; g_clr_s = 1; idle(0); g_clr_p = 0; g_clr_s = 0;
        g_pen = 0; g_sen = 0;
        step($urandom, 4'h0, 0, 0, 0, 1, 0, 0, 0); idle(1);
        step($urandom, 4'h0, 0, 0, 1, 0, 1, 1, 0); idle(1); idle(0); idle(0);
        g_pen = 1; g_sen = 1;
        // R9: clear in the same clock as a new detection, then a quiet clear
        tag = "R9";
        step($urandom, 4'h0, 0, 0, 0, 1, 0, 0, 0);
        g_clr_p = 1; idle(1); g_clr_p = 0; idle(0);
        g_clr_p = 1; idle(0); g_clr_p = 0; idle(0);
        step($urandom, 4'h0, 0, 0, 1, 0, 1, 1, 0);
        g_clr_s = 1; idle(1); g_clr_s = 0; idle(0);
        g_clr_s = 1; idle(0); g_clr_s = 0; idle(0);
        // random mix of all of the above
        tag = "R7";
        for (int i = 0; i < 4000; i++) begin
            g_clr_p = ($urandom % 8) == 0; g_clr_s = ($urandom % 8) == 0;
            g_pen = ($urandom % 6) != 0;   g_sen = ($urandom % 6) != 0;
            step($urandom, 4'($urandom), ($urandom % 3) == 0, 1'($urandom),
                 ($urandom % 5) == 0, 1'($urandom), ($urandom % 4) == 0,
                 ($urandom % 4) == 0, ($urandom % 4) == 0);
        end
        g_clr_p = 0; g_clr_s = 0; g_pen = 1; g_sen = 1;
        idle(0); idle(0); idle(0);
        @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule